// File: doc/BRIEF.md
# Column-Sliced LFSR Noise Bank

This block runs eight maximal-length linear feedback shift registers of the same length side by side. Their bits sit in a circular register file that is one byte wide and one entry deeper than the register length. Bit j of every entry belongs to lane j. A step never moves stage contents. Instead it XORs the byte at the oldest stage with the byte at the second tap, and stores the result in the single spare entry, called the hold slot. It then advances a head pointer by one, so that entry becomes the newest stage and the old oldest entry becomes the next hold slot.

The default polynomial is x^63 + x^62 + 1, so the default buffer is 64 bytes. The depth must be a power of two. The head pointer then wraps on its own bit width, with no compare and no branch, and a step costs one clock for any length. Each output byte is the feedback just computed, so each of its bits is one sample of one lane's noise stream. Software or a sequencer seeds all entries through the write port while the step input is low, then holds the step input high at whatever sample rate it needs.

Top module: `slice_lfsr_bank`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o is 0, data_o is 0 and the head pointer is 0, so the hold slot is address 0.
- R2: When seed_we_i is 1 and step_i is 0, seed_data_i is written at seed_addr_i. With head pointer p, stage k (1 = newest, LEN = oldest) lives at address (p - k) mod (LEN+1). After reset this is address LEN+1-k.
- R3: Each cycle with step_i high produces, one cycle later, valid_o = 1 for exactly one cycle, with data_o = byte(oldest stage) XOR byte(stage TAP).
- R4: Each bit column j of data_o follows a Fibonacci LFSR with polynomial x^LEN + x^TAP + 1. The output is s[LEN] ^ s[TAP], the stages shift one place towards s[LEN], and the output bit enters s[1].
- R5: The head pointer increments by one per step and wraps from LEN to 0 by truncation. Back-to-back steps keep R4 across any number of wraps.
- R6: A seed write in a cycle where step_i is high is ignored, and the stored stages are unchanged.
- R7: In a cycle with step_i low, the next cycle has valid_o = 0, and neither the head pointer nor any stored stage changes.
- R8: A lane whose column is seeded all zero outputs 0 on every step, while the other lanes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seed_we_i | input | 1 | Seed write strobe |
| seed_addr_i | input | AW | Seed write address, AW = clog2(LEN+1) |
| seed_data_i | input | LANES | Seed byte, one bit per lane |
| step_i | input | 1 | Advance all lanes by one stage |
| data_o | output | LANES | Latest feedback byte, one bit per lane |
| valid_o | output | 1 | One-cycle strobe, high the cycle after a step |

## Verification
The checker assumes that the step input is never unknown once reset is released. It also assumes LEN+1 is a power of two, so that a plain increment of the head pointer is the wrap. Its properties cover the valid strobe, pointer advance and pointer hold. The bench drives every input on the falling edge, and drives step_i from a fixed-seed random draw, so the step input is always 0 or 1. Seed writes made during a step always target a live stage and carry the complement of that stage's content, so a leaked write would change later output.

// File: rtl/slice_lfsr_pkg.sv
package slice_lfsr_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned LEN_DEF   = 63;
  localparam int unsigned TAP_DEF   = 62;

  // distance from the oldest stage to the second tap, in entries
  function automatic int unsigned tap_gap(input int unsigned len, input int unsigned tap);
    return len - tap;
  endfunction
endpackage

// File: rtl/lfsr_head_ptr.sv
module lfsr_head_ptr #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  // depth is 2**AW, so wrap is free truncation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_q + AW'(1);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/lfsr_slice_mem.sv
module lfsr_slice_mem #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] row_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              row_q[i] <= '0;
      else if (we_i && (waddr_i == AW'(i)))     row_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o = row_q[raddr_a_i];
  assign rdata_b_o = row_q[raddr_b_i];
endmodule

// File: rtl/lfsr_fb_xor.sv
module lfsr_fb_xor #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] tap_i,
  output logic [W-1:0] fb_o
);
  // one XOR per lane; lanes never interact
  for (genvar j = 0; j < W; j++) begin : g_lane
    assign fb_o[j] = old_i[j] ^ tap_i[j];
  end
endmodule

// File: rtl/slice_lfsr_bank.sv
module slice_lfsr_bank #(
  parameter int unsigned LANES = slice_lfsr_pkg::LANES_DEF,
  parameter int unsigned LEN   = slice_lfsr_pkg::LEN_DEF,
  parameter int unsigned TAP   = slice_lfsr_pkg::TAP_DEF,
  localparam int unsigned DEPTH = LEN + 1,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_we_i,
  input  logic [AW-1:0]    seed_addr_i,
  input  logic [LANES-1:0] seed_data_i,
  input  logic             step_i,
  output logic [LANES-1:0] data_o,
  output logic             valid_o
);
  localparam logic [AW-1:0] OFS_OLD = AW'(1);
  localparam logic [AW-1:0] OFS_TAP = AW'(1 + slice_lfsr_pkg::tap_gap(LEN, TAP));

  logic [AW-1:0]    ptr_q;
  logic [AW-1:0]    old_addr, tap_addr, waddr;
  logic [LANES-1:0] old_byte, tap_byte, fb_byte, wdata;
  logic             we;
  logic [LANES-1:0] data_q;
  logic             valid_q;

  lfsr_head_ptr #(.AW(AW)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (step_i),
    .ptr_o (ptr_q)
  );

  assign old_addr = ptr_q + OFS_OLD;
  assign tap_addr = ptr_q + OFS_TAP;

  // step owns the write port; seed writes during a step are dropped
  assign we    = step_i | seed_we_i;
  assign waddr = step_i ? ptr_q   : seed_addr_i;
  assign wdata = step_i ? fb_byte : seed_data_i;

  lfsr_slice_mem #(.W(LANES), .DEPTH(DEPTH)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .raddr_a_i(old_addr),
    .raddr_b_i(tap_addr),
    .rdata_a_o(old_byte),
    .rdata_b_o(tap_byte)
  );

  lfsr_fb_xor #(.W(LANES)) u_fb (
    .old_i(old_byte),
    .tap_i(tap_byte),
    .fb_o (fb_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step_i;
      if (step_i) data_q <= fb_byte;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/slice_lfsr_bank_chk.sv
module slice_lfsr_bank_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned W  = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic          valid_o,
  input logic [W-1:0]  data_o,
  input logic [AW-1:0] ptr_i
);
  a_r3_valid_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> valid_o);

  a_r7_no_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !valid_o);

  a_r5_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (ptr_i == AW'($past(ptr_i) + AW'(1))));

  a_r7_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(ptr_i));

  a_r3_data_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !$isunknown(data_o));
endmodule

bind slice_lfsr_bank slice_lfsr_bank_chk #(.AW(AW), .W(LANES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .step_i (step_i),
  .valid_o(valid_o),
  .data_o (data_o),
  .ptr_i  (ptr_q)
);

// File: tb/slice_lfsr_bank_tb_top.sv
`timescale 1ns/1ps
module slice_lfsr_bank_tb_top;
  localparam int LANES = 8;
  localparam int LEN   = 63;
  localparam int TAP   = 62;
  localparam int DEPTH = LEN + 1;
  localparam int AW    = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             seed_we_i;
  logic [AW-1:0]    seed_addr_i;
  logic [LANES-1:0] seed_data_i;
  logic             step_i;
  logic [LANES-1:0] data_o;
  logic             valid_o;

  always #2.5 clk_i = ~clk_i;

  slice_lfsr_bank #(.LANES(LANES), .LEN(LEN), .TAP(TAP)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .seed_we_i(seed_we_i), .seed_addr_i(seed_addr_i),
    .seed_data_i(seed_data_i), .step_i(step_i), .data_o(data_o), .valid_o(valid_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] ref_st [1:LEN];
  int         ptr_m = 0;
  bit         exp_pend = 0;
  logic [7:0] exp_data;
  string      req = "R1";

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic ref_step(output logic [7:0] fb);
    fb = ref_st[LEN] ^ ref_st[TAP];
    for (int k = LEN; k >= 2; k--) ref_st[k] = ref_st[k-1];
    ref_st[1] = fb;
  endtask

  // one negedge: check last cycle's outcome, then drive the next
  task automatic cycle(input bit do_step, input bit leak);
    logic [7:0] fb;
    @(negedge clk_i);
    if (exp_pend) begin
      chk(req, {31'd0, valid_o}, 32'd1);
      chk(req, {24'd0, data_o}, {24'd0, exp_data});
    end else begin
      chk("R7", {31'd0, valid_o}, 32'd0);
    end
    seed_we_i = 1'b0;
    step_i    = do_step;
    if (do_step) begin
      if (leak) begin
        // R6: aim at stage LEN-4 with its complement
        seed_we_i   = 1'b1;
        seed_addr_i = AW'((ptr_m - (LEN - 4)) & (DEPTH - 1));
        seed_data_i = ~ref_st[LEN-4];
      end
      ref_step(fb);
      exp_data = fb;
      ptr_m    = (ptr_m + 1) & (DEPTH - 1);
      exp_pend = 1;
    end else begin
      exp_pend = 0;
    end
  endtask

  task automatic seed_all(input logic [7:0] zero_lanes);
    cycle(0, 0);
    for (int k = 1; k <= LEN; k++) ref_st[k] = 8'($urandom) & ~zero_lanes;
    ref_st[1] = ref_st[1] | ~zero_lanes;
    for (int k = 1; k <= LEN; k++) begin
      @(negedge clk_i);
      seed_we_i   = 1'b1;
      seed_addr_i = AW'((ptr_m - k) & (DEPTH - 1));
      seed_data_i = ref_st[k];
    end
    @(negedge clk_i);
    seed_addr_i = AW'(ptr_m);        // hold slot: content is don't-care
    seed_data_i = 8'($urandom);
    @(negedge clk_i);
    seed_we_i = 1'b0;
    chk("R7", {31'd0, valid_o}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h1f3a_5eed));
    rst_ni = 1'b0; seed_we_i = 0; seed_addr_i = '0; seed_data_i = '0; step_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R1", {31'd0, valid_o}, 32'd0);
    chk("R1", {24'd0, data_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {31'd0, valid_o}, 32'd0);
    chk("R1", {24'd0, data_o}, 32'd0);

    // R2: seed mapping relative to hold slot 0, first output
    seed_all(8'h00);
    req = "R2";
    cycle(1, 0);
    cycle(0, 0);

    // R3: isolated steps, one-cycle strobe
    req = "R3";
    for (int i = 0; i < 20; i++) begin
      cycle(1, 0);
      cycle(0, 0);
      cycle(0, 0);
    end

    // R4: random step pattern against the reference lanes
    req = "R4";
    for (int i = 0; i < 3000; i++) cycle(($urandom % 5) != 0, 0);

    // R5: long back-to-back run across many pointer wraps
    req = "R5";
    for (int i = 0; i < 400; i++) cycle(1, 0);

    // R6: seed writes colliding with steps are dropped
    req = "R6";
    for (int i = 0; i < 40; i++) cycle(1, (i % 3) == 0);
    for (int i = 0; i < 200; i++) cycle(1, 0);

    // R8: lanes 0 and 5 seeded all zero stay silent
    seed_all(8'h21);
    req = "R8";
    for (int i = 0; i < 500; i++) begin
      cycle(($urandom % 4) != 0, 0);
      if (exp_pend) chk("R8", 32'({24'd0, exp_data} & 32'h21), 32'd0);
    end

    // R4 again from a fresh random seed
    seed_all(8'h00);
    req = "R4";
    for (int i = 0; i < 1500; i++) cycle(($urandom % 3) != 0, 0);
    cycle(0, 0);
    cycle(0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule